// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Stream

This block turns a one-bit delta-sigma bitstream into 16-bit parallel samples. It is a cascaded integrator-comb filter of order three with a decimation ratio of 256. Three running-sum stages work at the bit rate. A rate counter fires once every 256 clocks, and on that clock three differencing stages reduce the running sum to one filtered word. The result is offset binary: the code grows linearly with the density of ones in the stream, and an all-ones stream clamps to the top code.

The bit is captured on the falling edge of the filter clock, because the modulator launches it on the rising edge. A synchronous active-low reset empties all filter state. After reset the first three words come out flagged as unsettled, since their averaging windows still contain the zeros that reset left behind.

Top module: `sinc3_decim`

## Requirements
- R1: The input bit is sampled on the falling clock edge. A bit held at 1 only around falling edges and at 0 around rising edges is read as all ones.
- R2: `sample_vld` is high for exactly one clock per 256 clocks. It first appears in the cycle after the 257th rising edge at which `rst_n` is sampled high.
- R3: Once settled, a stream with k ones in every 256 consecutive bits gives `sample_o` = k × 256. A 50 % alternating stream gives 32768, and 228 or 28 ones per 256 bits give 58368 or 7168.
- R4: Densities of 13/16 and 3/16 settle to 53248 and 12288.
- R5: An all-ones stream, whose full-precision result is 2^24, clamps to 65535. An all-zeros stream gives 0.
- R6: While `rst_n` is low, `sample_o` reads 0 and `sample_vld` and `settled_o` read 0 from the first clock onward.
- R7: `settled_o` is 0 on the first three words after reset and 1 on every later word.
- R8: A reset that falls on the clock of a decimation update wins: no strobe follows and the word stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter and bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_bit | input | 1 | Serial modulator bit, launched on the rising edge |
| sample_o | output | 16 | Filtered offset-binary word |
| sample_vld | output | 1 | One-clock strobe marking a new word |
| settled_o | output | 1 | Word comes from a window fully after reset |

## Verification
A reset and a decimation update can land on the same rising edge. The bench locks onto the word strobe and counts 254 clocks from it. It then drops reset so that the next edge is the one on which the comb update would have happened, and holds reset for three clocks. It passes only if no strobe appears, the word reads 0, and the first word after release is flagged unsettled again.

// File: rtl/sinc3_pkg.sv
// Shared sizing helpers for the sinc decimator.
// Assumes input bits map to 0/+1, so the full-precision result never
// exceeds DR^ORDER, which needs ORDER*log2(DR)+1 bits.
package sinc3_pkg;

    // Accumulator width that holds DR^ORDER without ambiguity.
    function automatic int acc_bits(input int order, input int dec_log2);
        return order * dec_log2 + 1;
    endfunction

    // Width of a counter that saturates at `order`.
    function automatic int settle_bits(input int order);
        return $clog2(order + 1);
    endfunction

endpackage

// File: rtl/sinc3_capture.sv
// Falling-edge capture of the serial bit.
// Assumes the source launches the bit on the rising edge, so the
// falling edge sits in the middle of its valid window.
module sinc3_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic bit_o
);

    // Sample the bit at mid-window.
    always_ff @(negedge clk) begin
        if (!rst_n) bit_o <= 1'b0;
        else        bit_o <= bit_i;
    end

endmodule

// File: rtl/sinc3_integ.sv
// Cascade of ORDER running sums at the bit rate.
// Wraps modulo 2^ACC_W. The comb stages undo the wrap, provided ACC_W
// holds DR^ORDER.
module sinc3_integ #(
    parameter int ORDER = 3,
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] stage_q [ORDER];

    // Each stage adds the previous one. The first stage adds the 0/+1 bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= stage_q[0] + {{(ACC_W-1){1'b0}}, bit_i};
            for (int k = 1; k < ORDER; k++) stage_q[k] <= stage_q[k] + stage_q[k-1];
        end
    end

    assign acc_o = stage_q[ORDER-1];

endmodule

// File: rtl/sinc3_ratectr.sv
// Free-running divide-by-2^DEC_LOG2 counter.
// The enable is high on the clock where the count is all ones, one clock
// in every 2^DEC_LOG2.
module sinc3_ratectr #(
    parameter int DEC_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic en_o
);

    logic [DEC_LOG2-1:0] cnt_q;

    // Count bit clocks. The count wraps on its own.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign en_o = &cnt_q;

    // R2: the enable never lasts longer than one clock
    a_r2_en_single: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);

endmodule

// File: rtl/sinc3_comb.sv
// ORDER differencing stages, all evaluated in the enable cycle.
// Each stage's delay register holds its input from the previous update,
// so the chain is a pure sinc^ORDER with no pipeline lag.
module sinc3_comb #(
    parameter int ORDER = 3,
    parameter int ACC_W = 25,
    parameter int TOP_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [TOP_W-1:0] res_top_o
);

    logic [ACC_W-1:0] chain [ORDER+1];
    logic [ACC_W-1:0] dly_q [ORDER];
    logic [ACC_W-1:0] result_q;

    // Difference chain: each stage subtracts its value from one period ago.
    always_comb begin
        chain[0] = acc_i;
        for (int k = 0; k < ORDER; k++) chain[k+1] = chain[k] - dly_q[k];
    end

    // Store the stage inputs and the final difference on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
            result_q <= '0;
        end else if (en_i) begin
            for (int k = 0; k < ORDER; k++) dly_q[k] <= chain[k];
            result_q <= chain[ORDER];
        end
    end

    assign res_top_o = result_q[ACC_W-1 -: TOP_W];

    // R5: non-negative unity-gain taps keep the result at or below DR^ORDER
    a_r5_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
        result_q <= (ACC_W'(1) << (ACC_W-1)));

endmodule

// File: rtl/sinc3_outstage.sv
// Output register, one-clock strobe and settle flag.
// Takes the top OUT_W+1 bits of the result. The MSB set means full scale,
// which clamps. It updates one clock after the comb enable.
module sinc3_outstage #(
    parameter int OUT_W = 16,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [OUT_W:0]   res_top_i,
    output logic [OUT_W-1:0] word_o,
    output logic             valid_o,
    output logic             settled_o
);

    localparam int SC_W = sinc3_pkg::settle_bits(ORDER);

    logic            upd_q;
    logic [SC_W-1:0] words_q;

    // Delay the enable by one clock so the comb result is already stored.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= en_i;
    end

    // Latch the clamped word, raise the strobe and track settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o    <= '0;
            valid_o   <= 1'b0;
            settled_o <= 1'b0;
            words_q   <= '0;
        end else begin
            valid_o <= upd_q;
            if (upd_q) begin
                word_o    <= res_top_i[OUT_W] ? {OUT_W{1'b1}} : res_top_i[OUT_W-1:0];
                settled_o <= (words_q == SC_W'(ORDER));
                if (words_q != SC_W'(ORDER)) words_q <= words_q + 1'b1;
            end
        end
    end

    // R2: the word strobe lasts one clock
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: a full-scale result yields the top code
    a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && res_top_i[OUT_W]) |=> (word_o == {OUT_W{1'b1}}));

    // R7: the settle flag can only rise together with a word strobe
    a_r7_settle_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> valid_o);

endmodule

// File: rtl/sinc3_decim.sv
// Top of the sinc^ORDER decimator: capture, integrators, rate counter,
// combs and output stage. Decimation ratio is 2^DEC_LOG2. The output is
// offset binary with OUT_W bits, OUT_W <= ORDER*DEC_LOG2.
module sinc3_decim #(
    parameter int ORDER    = 3,
    parameter int DEC_LOG2 = 8,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] sample_o,
    output logic             sample_vld,
    output logic             settled_o
);

    localparam int ACC_W = sinc3_pkg::acc_bits(ORDER, DEC_LOG2);

    logic             bit_cap;
    logic [ACC_W-1:0] acc;
    logic             dec_en;
    logic [OUT_W:0]   res_top;

    sinc3_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (mod_bit),
        .bit_o (bit_cap)
    );

    sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (bit_cap),
        .acc_o (acc)
    );

    sinc3_ratectr #(.DEC_LOG2(DEC_LOG2)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en_o  (dec_en)
    );

    sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W), .TOP_W(OUT_W+1)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (dec_en),
        .acc_i     (acc),
        .res_top_o (res_top)
    );

    sinc3_outstage #(.OUT_W(OUT_W), .ORDER(ORDER)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (dec_en),
        .res_top_i (res_top),
        .word_o    (sample_o),
        .valid_o   (sample_vld),
        .settled_o (settled_o)
    );

endmodule

// File: tb/tb_sinc3_decim.sv
module tb_sinc3_decim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_bit = 1'b0;
    logic [15:0] sample_o;
    logic        sample_vld;
    logic        settled_o;

    int tests = 0;
    int fails = 0;
    int ones = 0;        // ones per 256 bits in density mode
    bit skew = 1'b0;     // drive 1 only around falling edges
    int phase = 0;

    sinc3_decim dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_bit    (mod_bit),
        .sample_o   (sample_o),
        .sample_vld (sample_vld),
        .settled_o  (settled_o)
    );

    always #5 clk = ~clk;

    function automatic bit pat_bit(input int n, input int k);
        return (((n + 1) * k) / 256 - (n * k) / 256) != 0;
    endfunction

    // Bit source: changes on the rising edge, like a modulator.
    always @(posedge clk) begin
        if (skew) begin
            #2 mod_bit = 1'b1;
            #5 mod_bit = 1'b0;
        end else begin
            mod_bit <= pat_bit(phase, ones);
            phase <= (phase + 1) % 256;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Hold reset, check the cleared outputs, release after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(sample_o == 0 && !sample_vld && !settled_o, "R6 reset state",
              {sample_o, 14'(0), sample_vld, settled_o}, 0);
        rst_n = 1'b1;
    endtask

    // Wait at falling edges for the strobe. Returns cycles waited, -1 on timeout.
    task automatic wait_vld(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_vld && n < 1000);
        if (!sample_vld) begin
            n = -1;
            check(1'b0, "watchdog strobe", 0, 1);
        end
    endtask

    // Run one density from reset and check six words.
    task automatic run_density(input int k, input string req);
        int n;
        int exp;
        exp = (k * 256 > 65535) ? 65535 : k * 256;
        skew = 1'b0;
        ones = k;
        do_reset();
        for (int w = 1; w <= 6; w++) begin
            wait_vld(n);
            if (n < 0) return;
            if (w == 1) check(n == 257, "R2 first strobe delay", n, 257);
            else        check(n == 256, "R2 strobe period", n, 256);
            check(settled_o == (w > 3), "R7 settle flag", settled_o, int'(w > 3));
            if (w >= 4) check(sample_o == exp, req, sample_o, exp);
            @(negedge clk);
            check(!sample_vld, "R2 strobe one clock", sample_vld, 0);
            if (w < 6) begin
                wait_vld(n);
                if (n < 0) return;
                n++;
                w++;
                check(n == 256, "R2 strobe period", n, 256);
                check(settled_o == (w > 3), "R7 settle flag", settled_o, int'(w > 3));
                if (w >= 4) check(sample_o == exp, req, sample_o, exp);
            end
        end
    endtask

    // Bit valid only around falling edges must read as ones.
    task automatic run_skew();
        int n;
        ones = 0;
        do_reset();
        skew = 1'b1;
        for (int w = 1; w <= 5; w++) begin
            wait_vld(n);
            if (n < 0) return;
        end
        check(sample_o == 65535, "R1 falling-edge capture", sample_o, 65535);
        skew = 1'b0;
    endtask

    // Reset on the clock of the comb update: reset wins.
    task automatic run_reset_collide();
        int n;
        int seen;
        skew = 1'b0;
        ones = 128;
        do_reset();
        for (int w = 1; w <= 4; w++) begin
            wait_vld(n);
            if (n < 0) return;
        end
        repeat (254) @(negedge clk);
        rst_n = 1'b0;
        seen = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (sample_vld) seen++;
        end
        check(seen == 0, "R8 no strobe under reset", seen, 0);
        check(sample_o == 0, "R8 word cleared", sample_o, 0);
        rst_n = 1'b1;
        wait_vld(n);
        if (n < 0) return;
        check(n == 257, "R8 restart timing", n, 257);
        check(!settled_o, "R8 R7 settle restarts", settled_o, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        run_density(128, "R3 half density");
        run_density(208, "R4 high density");
        run_density(48,  "R4 low density");
        run_density(256, "R5 all ones clamp");
        run_density(0,   "R5 all zeros");
        run_density(228, "R3 linear high");
        run_density(28,  "R3 linear low");
        run_skew();
        run_reset_collide();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule